// File: doc/BRIEF.md
# Dual-Channel Sigma-Delta Digital Front End

This block is the digital side of a two-channel 1-bit sigma-delta converter. It runs from the external measurement clock and receives two raw modulator bitstreams, one from the voltage channel and one from the current channel. Each stream is registered once per conversion period. The two registered bits then share one serial line: the voltage bit is sent while the measurement clock is high and the current bit while it is low. A complement of that line is also driven.

The block derives the switched-capacitor timing for the analog side from the same clock. This timing has two mutually exclusive conversion phases at half the clock rate, one chopper for the voltage channel and a complementary chopper pair for the current channel. It also decodes two strap pins. The gain strap selects the current-channel gain. The trim strap is decoded into one of four reference temperature-coefficient codes by comparing it with the clock over a fixed window.

Top module: `dmod_frontend`

## Requirements
- R1: `ser_dat` equals the registered voltage bit while `meas_clk` is 1 and the registered current bit while `meas_clk` is 0.
- R2: `ser_dat_n` is always the logical inverse of `ser_dat`.
- R3: Both bitstreams are captured together on every second rising edge after reset release, counting from 1 and starting with edge 2. Each captured bit is held for two clock cycles.
- R4: After rising edge k since reset release (k=0 is the reset state), `conv_ph1` is 1 for even k and `conv_ph2` is 1 for odd k. The two are never 1 together.
- R5: `chop_volt` and `chop_cur_p` equal bit 0 of floor(k/8). They toggle once every four conversion periods. `chop_cur_n` is their complement.
- R6: `gain_x32` takes the value of `strap_gain` at each rising edge. A value of 1 selects a total current gain of 32 and 0 selects 8.
- R7: The trim code is formed from a pair of samples: the level of `strap_tc` just before a falling edge (hi) and the level just before the next rising edge (lo). The encoding is hi=0,lo=0 gives 0 (100 ppm/°C); hi=1,lo=0 gives 1 (170); hi=0,lo=1 gives 2 (125); hi=1,lo=1 gives 3 (190).
- R8: Pairs are grouped into fixed windows of 8 rising edges, the first window starting at edge 2. A window commits its code to `tc_trim` at its last edge only if all 8 pairs decode alike. Otherwise `tc_trim` is kept unchanged.
- R9: While `rst_n` is 0, `ser_dat`, both conversion phases, `chop_volt`, `chop_cur_p`, `gain_x32` and `tc_trim` are 0, and `chop_cur_n` and `ser_dat_n` are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| meas_clk | input | 1 | External measurement clock |
| rst_n | input | 1 | Supply-monitor reset, active low, asynchronous |
| strap_gain | input | 1 | Current-gain strap (0: x8, 1: x32) |
| strap_tc | input | 1 | Four-state trim strap (low, clock, inverted clock, high) |
| bs_volt | input | 1 | Voltage-channel modulator bit |
| bs_curr | input | 1 | Current-channel modulator bit |
| ser_dat | output | 1 | Time-multiplexed serial output |
| ser_dat_n | output | 1 | Complement of ser_dat |
| conv_ph1 | output | 1 | Conversion phase 1 |
| conv_ph2 | output | 1 | Conversion phase 2 |
| chop_volt | output | 1 | Voltage-channel chopper |
| chop_cur_p | output | 1 | Current-channel chopper, true |
| chop_cur_n | output | 1 | Current-channel chopper, complement |
| gain_x32 | output | 1 | Decoded current gain select |
| tc_trim | output | 2 | Decoded reference trim code |

## Verification
The hardest case is a trim strap that changes state part way through a decode window, because windows are aligned to reset release and not to the stimulus. The stimulus switches the strap between the four states every five cycles. This gives windows that mix two patterns and, by chance, windows that are uniform. A mid-run reset then realigns the windows. The bench model follows its own window count, so it can tell which windows must commit and which must keep the previous code.

// File: rtl/dmod_pkg.sv
package dmod_pkg;

    typedef enum logic [1:0] {
        TC_TIED_LOW  = 2'd0,
        TC_FOLLOW    = 2'd1,
        TC_INVERTED  = 2'd2,
        TC_TIED_HIGH = 2'd3
    } tc_code_e;

    // Map the level seen in the high phase and in the low phase to a code.
    function automatic tc_code_e tc_from_levels(input logic hi_lvl, input logic lo_lvl);
        tc_code_e r;
        case ({hi_lvl, lo_lvl})
            2'b00:   r = TC_TIED_LOW;
            2'b10:   r = TC_FOLLOW;
            2'b01:   r = TC_INVERTED;
            default: r = TC_TIED_HIGH;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dmod_phase_gen.sv
module dmod_phase_gen #(
    parameter int CHOP_CONV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic ph1,
    output logic ph2,
    output logic chop_v,
    output logic chop_cp,
    output logic chop_cn,
    output logic cap_en
);
    localparam int CYC = 2 * CHOP_CONV;
    localparam int CW  = $clog2(CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          chop;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CW'(CYC - 1)) begin
            st_d.cnt  = '0;
            st_d.chop = ~st_q.chop;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ph1     = rst_n & ~st_q.cnt[0];
    assign ph2     = rst_n &  st_q.cnt[0];
    assign chop_v  = st_q.chop;
    assign chop_cp = st_q.chop;
    assign chop_cn = ~st_q.chop;
    assign cap_en  = st_q.cnt[0];
endmodule

// File: rtl/dmod_sample_reg.sv
module dmod_sample_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic bs_v,
    input  logic bs_c,
    output logic v_bit,
    output logic c_bit
);
    typedef struct packed {
        logic v;
        logic c;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d = smp_q;
        if (cap_en) begin
            smp_d.v = bs_v;
            smp_d.c = bs_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign v_bit = smp_q.v;
    assign c_bit = smp_q.c;
endmodule

// File: rtl/dmod_strap_dec.sv
module dmod_strap_dec
    import dmod_pkg::*;
#(
    parameter int WIN = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_gain,
    input  logic       strap_tc,
    output logic       gain32,
    output logic [1:0] tc_code
);
    localparam int WW = $clog2(WIN + 1);

    typedef struct packed {
        logic hi;
        logic primed;
    } neg_t;

    typedef struct packed {
        logic [WW-1:0] win;
        tc_code_e      cand;
        logic          ok;
        tc_code_e      code;
        logic          gain;
    } pos_t;

    neg_t n_d, n_q;
    pos_t p_d, p_q;

    tc_code_e pat;
    logic     match_ok;
    tc_code_e cand_use;

    always_comb begin
        n_d.hi     = strap_tc;
        n_d.primed = 1'b1;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) n_q <= '0;
        else        n_q <= n_d;
    end

    always_comb begin
        pat      = tc_from_levels(n_q.hi, strap_tc);
        match_ok = (p_q.win == '0) ? 1'b1 : (p_q.ok && (pat == p_q.cand));
        cand_use = (p_q.win == '0) ? pat : p_q.cand;
        p_d      = p_q;
        p_d.gain = strap_gain;
        if (n_q.primed) begin
            p_d.ok   = match_ok;
            p_d.cand = cand_use;
            if (p_q.win == WW'(WIN - 1)) begin
                p_d.win = '0;
                if (match_ok) p_d.code = cand_use;
            end else begin
                p_d.win = p_q.win + WW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.win  <= '0;
            p_q.cand <= TC_TIED_LOW;
            p_q.ok   <= 1'b0;
            p_q.code <= TC_TIED_LOW;
            p_q.gain <= 1'b0;
        end else begin
            p_q <= p_d;
        end
    end

    assign gain32  = p_q.gain;
    assign tc_code = p_q.code;
endmodule

// File: rtl/dmod_frontend.sv
module dmod_frontend #(
    parameter int WIN_CYC   = 8,
    parameter int CHOP_CONV = 4
) (
    input  logic       meas_clk,
    input  logic       rst_n,
    input  logic       strap_gain,
    input  logic       strap_tc,
    input  logic       bs_volt,
    input  logic       bs_curr,
    output logic       ser_dat,
    output logic       ser_dat_n,
    output logic       conv_ph1,
    output logic       conv_ph2,
    output logic       chop_volt,
    output logic       chop_cur_p,
    output logic       chop_cur_n,
    output logic       gain_x32,
    output logic [1:0] tc_trim
);
    logic cap_en;
    logic v_bit;
    logic c_bit;

    dmod_phase_gen #(.CHOP_CONV(CHOP_CONV)) phase_i (
        .clk     (meas_clk),
        .rst_n   (rst_n),
        .ph1     (conv_ph1),
        .ph2     (conv_ph2),
        .chop_v  (chop_volt),
        .chop_cp (chop_cur_p),
        .chop_cn (chop_cur_n),
        .cap_en  (cap_en)
    );

    dmod_sample_reg sample_i (
        .clk    (meas_clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .bs_v   (bs_volt),
        .bs_c   (bs_curr),
        .v_bit  (v_bit),
        .c_bit  (c_bit)
    );

    dmod_strap_dec #(.WIN(WIN_CYC)) strap_i (
        .clk        (meas_clk),
        .rst_n      (rst_n),
        .strap_gain (strap_gain),
        .strap_tc   (strap_tc),
        .gain32     (gain_x32),
        .tc_code    (tc_trim)
    );

    // Clock-level interleave: voltage bit in the high phase, current in the low.
    assign ser_dat   = meas_clk ? v_bit : c_bit;
    assign ser_dat_n = ~ser_dat;
endmodule

// File: rtl/dmod_frontend_chk.sv
module dmod_frontend_chk (
    input logic       meas_clk,
    input logic       rst_n,
    input logic       strap_gain,
    input logic       ser_dat,
    input logic       ser_dat_n,
    input logic       conv_ph1,
    input logic       conv_ph2,
    input logic       chop_volt,
    input logic       chop_cur_p,
    input logic       chop_cur_n,
    input logic       gain_x32
);
    // R2
    a_r2_dat_complement: assert property (@(posedge meas_clk) disable iff (!rst_n)
        ser_dat_n == ~ser_dat);
    // R4
    a_r4_phases_exclusive: assert property (@(posedge meas_clk) disable iff (!rst_n)
        !(conv_ph1 && conv_ph2));
    a_r4_ph1_then_ph2: assert property (@(posedge meas_clk) disable iff (!rst_n)
        conv_ph1 |=> conv_ph2);
    a_r4_ph2_then_ph1: assert property (@(posedge meas_clk) disable iff (!rst_n)
        conv_ph2 |=> conv_ph1);
    // R5
    a_r5_cur_chop_complement: assert property (@(posedge meas_clk) disable iff (!rst_n)
        chop_cur_p != chop_cur_n);
    a_r5_chop_pair_equal: assert property (@(posedge meas_clk) disable iff (!rst_n)
        chop_volt == chop_cur_p);
    a_r5_chop_moves_on_ph1: assert property (@(posedge meas_clk) disable iff (!rst_n)
        (chop_volt != $past(chop_volt)) |-> conv_ph1);
    // R6
    a_r6_gain_tracks_strap: assert property (@(posedge meas_clk) disable iff (!rst_n)
        1'b1 |=> gain_x32 == $past(strap_gain));
endmodule

bind dmod_frontend dmod_frontend_chk chk_i (
    .meas_clk   (meas_clk),
    .rst_n      (rst_n),
    .strap_gain (strap_gain),
    .ser_dat    (ser_dat),
    .ser_dat_n  (ser_dat_n),
    .conv_ph1   (conv_ph1),
    .conv_ph2   (conv_ph2),
    .chop_volt  (chop_volt),
    .chop_cur_p (chop_cur_p),
    .chop_cur_n (chop_cur_n),
    .gain_x32   (gain_x32)
);

// File: tb/dmod_frontend_tb.sv
`timescale 1ns/1ps
module dmod_frontend_tb_top;
    localparam int WIN = 8;

    logic       meas_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_gain = 1'b0;
    logic       strap_tc = 1'b0;
    logic       bs_volt = 1'b0;
    logic       bs_curr = 1'b0;
    logic       ser_dat, ser_dat_n, conv_ph1, conv_ph2;
    logic       chop_volt, chop_cur_p, chop_cur_n, gain_x32;
    logic [1:0] tc_trim;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int       tc_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    // reference model state
    int   k = 0;
    int   exp_code = 0;
    int   w_cand = 0;
    bit   w_ok = 1'b0;
    bit   exp_v = 1'b0, exp_c = 1'b0, exp_gain = 1'b0;
    bit   hi_lvl = 1'b0, lo_lvl = 1'b0;

    always #2.5 meas_clk = ~meas_clk;

    dmod_frontend dut_i (
        .meas_clk(meas_clk), .rst_n(rst_n), .strap_gain(strap_gain), .strap_tc(strap_tc),
        .bs_volt(bs_volt), .bs_curr(bs_curr), .ser_dat(ser_dat), .ser_dat_n(ser_dat_n),
        .conv_ph1(conv_ph1), .conv_ph2(conv_ph2), .chop_volt(chop_volt),
        .chop_cur_p(chop_cur_p), .chop_cur_n(chop_cur_n), .gain_x32(gain_x32),
        .tc_trim(tc_trim)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at t=%0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // strap_tc generator: follows the chosen state shortly after each clock change
    always @(meas_clk) begin
        #0.5;
        case (tc_mode)
            0:       strap_tc = 1'b0;
            1:       strap_tc = meas_clk;
            2:       strap_tc = ~meas_clk;
            default: strap_tc = 1'b1;
        endcase
    end

    // modulator behavioural stand-in: pseudo-random bits changed mid low phase
    always @(negedge meas_clk) begin
        #0.5;
        lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        bs_volt = lfsr[0];
        bs_curr = lfsr[5];
    end

    function automatic int code_of(input bit hi, input bit lo);
        if (!hi && !lo) return 0;
        if (hi && !lo)  return 1;
        if (!hi && lo)  return 2;
        return 3;
    endfunction

    always @(posedge meas_clk) begin
        #1.25;
        if (!rst_n) begin
            k = 0; exp_code = 0; w_cand = 0; w_ok = 0;
            exp_v = 0; exp_c = 0; exp_gain = 0;
            check("R9 ser_dat", ser_dat, 0);
            check("R9 ser_dat_n", ser_dat_n, 1);
            check("R9 ph1", conv_ph1, 0);
            check("R9 ph2", conv_ph2, 0);
            check("R9 chop_volt", chop_volt, 0);
            check("R9 chop_cur_n", chop_cur_n, 1);
            check("R9 gain", gain_x32, 0);
            check("R9 tc_trim", tc_trim, 0);
        end else begin
            k++;
            exp_gain = strap_gain;
            if (k >= 2 && (k % 2) == 0) begin
                exp_v = bs_volt;
                exp_c = bs_curr;
            end
            if (k >= 2) begin
                int p;
                int pat;
                p   = (k - 2) % WIN;
                pat = code_of(hi_lvl, lo_lvl);
                if (p == 0) begin w_cand = pat; w_ok = 1; end
                else if (pat != w_cand) w_ok = 0;
                if (p == WIN - 1 && w_ok) exp_code = w_cand;
            end
            check("R1 high-phase voltage bit", ser_dat, exp_v);
            check("R2 complement", ser_dat_n, !exp_v);
            check("R3/R4 ph1", conv_ph1, (k % 2) == 0);
            check("R4 ph2", conv_ph2, (k % 2) == 1);
            check("R5 chop_volt", chop_volt, (k / 8) % 2);
            check("R5 chop_cur_p", chop_cur_p, (k / 8) % 2);
            check("R5 chop_cur_n", chop_cur_n, 1 - ((k / 8) % 2));
            check("R6 gain", gain_x32, exp_gain);
            check("R7/R8 tc_trim", tc_trim, exp_code);
        end
        hi_lvl = strap_tc;
    end

    always @(negedge meas_clk) begin
        #1.25;
        lo_lvl = strap_tc;
        if (!rst_n) begin
            check("R9 ser_dat low phase", ser_dat, 0);
        end else begin
            check("R1 low-phase current bit", ser_dat, exp_c);
            check("R2 complement low phase", ser_dat_n, !exp_c);
        end
    end

    task automatic run_cycles(input int n);
        repeat (n) @(posedge meas_clk);
    endtask

    task automatic set_mode(input int m);
        @(posedge meas_clk); #2;
        tc_mode = m;
    endtask

    initial begin
        #21 rst_n = 1'b1;
        // R7 each static and clock-related strap state
        set_mode(1); strap_gain = 1'b1; run_cycles(30);
        set_mode(2); run_cycles(30);
        set_mode(3); strap_gain = 1'b0; run_cycles(30);
        set_mode(0); run_cycles(30);
        // R8 strap moving inside windows
        for (int i = 0; i < 16; i++) begin
            set_mode((i * 3 + 1) % 4);
            strap_gain = i[0];
            run_cycles(4);
        end
        set_mode(2); run_cycles(30);
        // R8 short glitch inside one window keeps code
        set_mode(1); run_cycles(2);
        set_mode(2); run_cycles(30);
        // R9 mid-run reset realigns windows
        @(negedge meas_clk); #1 rst_n = 1'b0;
        run_cycles(3);
        @(negedge meas_clk); #1 rst_n = 1'b1;
        set_mode(3); run_cycles(40);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule